// File: doc/BRIEF.md
# Status Pin Serial Offset Streamer

This block owns one status output pin and decides, from a two-bit mode code, what that pin carries. It can pass through a general decoder status bit, pass through a measurement-ready flag, hold the pin low, or send an 8-bit offset result as a UART-compatible serial stream. In stream mode the frame repeats on its own, with no request from the receiver. Each frame is a low start bit, eight data bits sent least significant first, and a high stop bit. After the stop bit the line stays high until the next frame starts. The most significant data bit is sent inverted, so the receiver must flip it back.

The bit period and the interval between frame starts are both given as clock-cycle counts at base speed. At run time both counts are divided by a speed factor n of 1, 2 or 4, which comes from two select bits. The offset byte is captured at the clock edge that starts each frame, so a frame never mixes two values. The output pin is registered. A change of mode takes effect on the next clock and abandons any frame in progress. When stream mode is entered again, a new frame starts at once.

Top module: `status_streamer`

## Requirements
- R1: With mode code 00 the pin shows, after each clock edge, the status input sampled at that edge (one cycle of latency).
- R2: With mode code 01 the pin shows the ready-flag input with one cycle of latency.
- R3: With mode code 11 the pin is driven low one cycle later, whatever the other inputs do.
- R4: With mode code 10, each frame is one low start bit, then data bits 0 to 7 in that order, then one high stop bit. The line stays high from the stop bit until the next start bit.
- R5: The transmitted bit 7 is the complement of bit 7 of the offset input. Bits 0 to 6 are sent unchanged.
- R6: Each bit lasts BIT_CYC/n clock cycles.
- R7: Frame start bits begin every FRAME_CYC/n clock cycles, and frames repeat for as long as mode 10 is held.
- R8: Speed select 00 gives n = 1, 01 gives n = 2, and any code with bit 1 set gives n = 4.
- R9: The offset byte is sampled at the edge that puts the start bit on the pin. A change of the input during a frame appears only in the next frame.
- R10: Leaving mode 10 stops the frame at once: the new source appears on the pin one cycle later. Entering mode 10 puts a start bit on the pin one cycle later.
- R11: While reset is asserted the pin is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Pin source: 00 status, 01 ready, 10 stream, 11 low |
| speed_sel | input | 2 | Speed factor select: 00 n=1, 01 n=2, 1x n=4 |
| status_bit | input | 1 | General decoder status bit |
| ready_flag | input | 1 | Offset measurement ready flag |
| offset_val | input | 8 | Offset byte to stream |
| status_pin | output | 1 | Registered status output pin |

## Verification
The assertions check on every cycle the one-cycle pass-through of the status and ready sources, the forced-low mode, and the reset of the frame counters whenever stream mode is left. They also check that the captured byte stays fixed between frame starts and that the bit index never runs past the idle state. The exact waveform can only be shown by the bench scenarios, which compare every sample of whole frames against a model computed from the requirements. This covers bit order, the inverted MSB, bit and frame lengths at each speed factor, the byte change in mid-frame, and a frame restart after an abort.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic [1:0] {
    PIN_STATUS = 2'b00,
    PIN_READY  = 2'b01,
    PIN_STREAM = 2'b10,
    PIN_LOW    = 2'b11
  } pin_mode_e;

  localparam int unsigned FRAME_BITS = 10;  // start + 8 data + stop
  localparam logic [3:0]  IDX_IDLE   = 4'd10;

  // speed select to right-shift amount (n = 1, 2, 4)
  function automatic logic [1:0] speed_shift(input logic [1:0] sel);
    if (sel[1])      return 2'd2;
    else if (sel[0]) return 2'd1;
    else             return 2'd0;
  endfunction

endpackage

// File: rtl/stp_rate.sv
module stp_rate
  import stp_pkg::*;
#(
  parameter int unsigned BIT_CYC   = 8,
  parameter int unsigned FRAME_CYC = 128,
  parameter int unsigned BW        = $clog2(BIT_CYC + 1),
  parameter int unsigned FW        = $clog2(FRAME_CYC + 1)
) (
  input  logic [1:0]    speed_sel,
  output logic [BW-1:0] bit_len,
  output logic [FW-1:0] frame_len
);

  logic [1:0] sh;

  always_comb begin
    sh        = speed_shift(speed_sel);
    bit_len   = BW'(BIT_CYC) >> sh;
    frame_len = FW'(FRAME_CYC) >> sh;
  end

  initial begin
    a_r6_bit_div4 : assert (BIT_CYC % 4 == 0 && BIT_CYC >= 4)
      else $error("BIT_CYC must be a multiple of 4");
    a_r7_frame_fits : assert (FRAME_CYC >= FRAME_BITS * BIT_CYC && FRAME_CYC % 4 == 0)
      else $error("FRAME_CYC too short for one frame");
  end

endmodule

// File: rtl/stp_serializer.sv
module stp_serializer
  import stp_pkg::*;
#(
  parameter int unsigned BW = 4,
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [BW-1:0] bit_len,
  input  logic [FW-1:0] frame_len,
  input  logic [7:0]    offset_in,
  output logic          line_nxt
);

  localparam logic [BW-1:0] B_ONE = BW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  logic [FW-1:0] fcnt;
  logic [BW-1:0] bcnt;
  logic [3:0]    idx;
  logic [7:0]    byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
    end else if (en && fcnt == '0) begin
      byte_q <= {~offset_in[7], offset_in[6:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      fcnt <= '0;
      bcnt <= '0;
      idx  <= '0;
    end else if (fcnt >= frame_len - F_ONE) begin
      fcnt <= '0;
      bcnt <= '0;
      idx  <= '0;
    end else begin
      fcnt <= fcnt + F_ONE;
      if (bcnt >= bit_len - B_ONE) begin
        bcnt <= '0;
        if (idx != IDX_IDLE) idx <= idx + 4'd1;
      end else begin
        bcnt <= bcnt + B_ONE;
      end
    end
  end

  always_comb begin
    if (idx == 4'd0)      line_nxt = 1'b0;
    else if (idx <= 4'd8) line_nxt = byte_q[3'(idx - 4'd1)];
    else                  line_nxt = 1'b1;
  end

  a_r4_idx_bound : assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_IDLE);

  a_r10_abort_clears : assert property (@(posedge clk) disable iff (rst)
    !en |=> (fcnt == '0 && idx == 4'd0 && bcnt == '0));

  a_r9_byte_held : assert property (@(posedge clk) disable iff (rst)
    (!en || fcnt != '0) |=> $stable(byte_q));

  a_r6_bit_hold : assert property (@(posedge clk) disable iff (rst)
    (en && bcnt < bit_len - B_ONE && fcnt < frame_len - F_ONE) |=> idx == $past(idx));

endmodule

// File: rtl/status_streamer.sv
module status_streamer
  import stp_pkg::*;
#(
  parameter int unsigned BIT_CYC   = 8,
  parameter int unsigned FRAME_CYC = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic [1:0] speed_sel,
  input  logic       status_bit,
  input  logic       ready_flag,
  input  logic [7:0] offset_val,
  output logic       status_pin
);

  localparam int unsigned BW = $clog2(BIT_CYC + 1);
  localparam int unsigned FW = $clog2(FRAME_CYC + 1);

  pin_mode_e     mode;
  logic [BW-1:0] bit_len;
  logic [FW-1:0] frame_len;
  logic          ser_line;
  logic          ser_en;

  assign mode   = pin_mode_e'(mode_sel);
  assign ser_en = (mode == PIN_STREAM);

  stp_rate #(
    .BIT_CYC  (BIT_CYC),
    .FRAME_CYC(FRAME_CYC),
    .BW       (BW),
    .FW       (FW)
  ) u_rate (
    .speed_sel(speed_sel),
    .bit_len  (bit_len),
    .frame_len(frame_len)
  );

  stp_serializer #(
    .BW(BW),
    .FW(FW)
  ) u_ser (
    .clk      (clk),
    .rst      (rst),
    .en       (ser_en),
    .bit_len  (bit_len),
    .frame_len(frame_len),
    .offset_in(offset_val),
    .line_nxt (ser_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_pin <= 1'b1;
    end else begin
      unique case (mode)
        PIN_STATUS: status_pin <= status_bit;
        PIN_READY:  status_pin <= ready_flag;
        PIN_STREAM: status_pin <= ser_line;
        PIN_LOW:    status_pin <= 1'b0;
      endcase
    end
  end

  a_r1_status_follow : assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (status_pin == $past(status_bit)));

  a_r2_ready_follow : assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (status_pin == $past(ready_flag)));

  a_r3_forced_low : assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> !status_pin);

endmodule

// File: tb/tb_status_streamer.sv
module tb_status_streamer;

  localparam int CLK_PER   = 10;
  localparam int BIT_CYC   = 8;
  localparam int FRAME_CYC = 128;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic [1:0] speed_sel;
  logic       status_bit;
  logic       ready_flag;
  logic [7:0] offset_val;
  logic       status_pin;

  int checks = 0;
  int errors = 0;

  status_streamer #(.BIT_CYC(BIT_CYC), .FRAME_CYC(FRAME_CYC)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .speed_sel(speed_sel),
    .status_bit(status_bit), .ready_flag(ready_flag),
    .offset_val(offset_val), .status_pin(status_pin)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [7:0] b, input int L, input int F);
    int j = (k - 1) % F;
    int i = j / L;
    if (i == 0) return 1'b0;
    if (i == 8) return ~b[7];
    if (i < 8)  return b[i-1];
    return 1'b1;
  endfunction

  // Stream scenario: compares every sample; optional offset change after sample chg_k
  task automatic run_stream(input logic [7:0] b, input logic [1:0] spd, input int nsamp,
                            input int chg_k, input logic [7:0] b2, input string req);
    int sh = spd[1] ? 2 : (spd[0] ? 1 : 0);
    int L  = BIT_CYC >> sh;
    int F  = FRAME_CYC >> sh;
    int bad = 0;
    logic first_act = 1'b0;
    logic first_exp = 1'b0;
    @(negedge clk);
    mode_sel = 2'b00;
    @(negedge clk);
    mode_sel   = 2'b10;
    speed_sel  = spd;
    offset_val = b;
    for (int k = 1; k <= nsamp; k++) begin
      logic [7:0] use_b;
      logic e;
      @(posedge clk);
      @(negedge clk);
      use_b = (chg_k > 0 && (k - 1) >= F) ? b2 : b;
      e = exp_bit(k, use_b, L, F);
      if (status_pin !== e) begin
        if (bad == 0) begin first_act = status_pin; first_exp = e; end
        bad++;
      end
      if (chg_k > 0 && k == chg_k) offset_val = b2;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d bad samples, first actual=%b expected=%b", req, bad, first_act, first_exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; mode_sel = 2'b11; speed_sel = 2'b00;
    status_bit = 1'b0; ready_flag = 1'b0; offset_val = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset high", status_pin, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_status();
    @(negedge clk); mode_sel = 2'b00; status_bit = 1'b1; ready_flag = 1'b0;
    @(negedge clk); check("R1 status=1", status_pin, 1'b1);
    status_bit = 1'b0; ready_flag = 1'b1;
    @(negedge clk); check("R1 status=0", status_pin, 1'b0);
  endtask

  task automatic t_ready();
    @(negedge clk); mode_sel = 2'b01; ready_flag = 1'b1; status_bit = 1'b0;
    @(negedge clk); check("R2 ready=1", status_pin, 1'b1);
    ready_flag = 1'b0; status_bit = 1'b1;
    @(negedge clk); check("R2 ready=0", status_pin, 1'b0);
  endtask

  task automatic t_low();
    @(negedge clk); mode_sel = 2'b11; status_bit = 1'b1; ready_flag = 1'b1; offset_val = 8'hFF;
    @(negedge clk); check("R3 low", status_pin, 1'b0);
    status_bit = 1'b0;
    @(negedge clk); check("R3 low held", status_pin, 1'b0);
  endtask

  task automatic t_abort();
    @(negedge clk); mode_sel = 2'b10; speed_sel = 2'b00; offset_val = 8'h00;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check("R10 in start bit", status_pin, 1'b0);
    mode_sel = 2'b00; status_bit = 1'b1;
    @(negedge clk); check("R10 abort to status", status_pin, 1'b1);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_status();
    t_ready();
    t_low();
    run_stream(8'hA5, 2'b00, 2*FRAME_CYC + 12, 0, 8'h00, "R4 R5 R6 R7 n=1 0xA5");
    run_stream(8'h3C, 2'b00, FRAME_CYC + 12, 0, 8'h00, "R4 R5 n=1 0x3C");
    run_stream(8'h81, 2'b01, FRAME_CYC + 4, 0, 8'h00, "R8 n=2 0x81");
    run_stream(8'h7E, 2'b10, FRAME_CYC, 0, 8'h00, "R8 n=4 0x7E");
    run_stream(8'hC3, 2'b11, FRAME_CYC, 0, 8'h00, "R8 code 11 gives n=4");
    run_stream(8'h96, 2'b00, 2*FRAME_CYC, 20, 8'h4B, "R9 mid-frame change");
    t_abort();
    run_stream(8'h5A, 2'b00, FRAME_CYC + 4, 0, 8'h00, "R10 restart frame");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule